// File: doc/BRIEF.md
# Pipelined Floating-Point Multiplier

This block multiplies two floating-point operands in a compact format with an implicit leading one, a biased exponent and a separate sign bit. It accepts one operand pair per clock under a valid strobe and returns one product per clock, with a fixed latency. Inside, the two significands, each with its hidden one restored, go through a generic pipelined integer multiplier. The exponents are added and one bias is taken away, and the sign is the exclusive-or of the input signs.

The significands are normalized, so the raw product lies in [1, 4). A single register stage after the multiplier looks at the top product bit and does three things. It selects one of two fraction windows. It adds that bit to the exponent. It forces the result to zero when either operand was zero. Results are truncated, and exponent overflow or underflow wraps silently. The block does not handle denormals, NaN or infinity. It is meant as a fixed-latency datapath element in a larger arithmetic pipeline.

Top module: `fp_mul_pipe`

## Requirements
- R1: An operand word holds the sign at its most significant bit, then EXP_W exponent bits, then FRAC_W fraction bits at the least significant end. Its value is (-1)^sign × 1.fraction × 2^(exponent − bias), with bias = 2^(EXP_W−1) − 1. The result uses the same layout.
- R2: The result sign equals the exclusive-or of the two operand signs.
- R3: When the significand product is below 2, the result exponent is ea + eb − bias and the fraction is taken from the product bits directly below the leading one.
- R4: When the significand product is 2 or more (top product bit set), the result fraction is taken one bit position higher and the exponent is incremented by one.
- R5: Fraction bits below the kept window are discarded with no rounding.
- R6: If either operand has an all-zero exponent field, the whole result word is zero.
- R7: valid_o goes high exactly MUL_LAT+1 clock cycles after a cycle in which valid_i was high (6 with defaults), and stays low otherwise. Back-to-back inputs give back-to-back results.
- R8: While rst_ni is low, and until the first accepted operand pair emerges, valid_o is low and result_o is zero.
- R9: An exponent result outside the representable range wraps modulo 2^EXP_W, with no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand pair valid this cycle |
| a_i | input | 1+EXP_W+FRAC_W | First operand |
| b_i | input | 1+EXP_W+FRAC_W | Second operand |
| valid_o | output | 1 | Product valid this cycle |
| result_o | output | 1+EXP_W+FRAC_W | Product |

## Verification
The bench builds the block with EXP_W=8, FRAC_W=23 and MUL_LAT=5. This gives the full 24×24-bit significand product, so the truncation window and both normalization positions can be checked at real width, and the latency of 6 cycles can be measured. The 8-bit exponent lets directed operands drive the biased sum past 255 and below 1, which exercises wraparound in both directions. Random operands with a sparse valid strobe and occasional zero exponents mix zero forcing, pipeline bubbles and back-to-back traffic.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef struct packed {
    logic vld;
    logic sign;
    logic zero;
  } fpm_ctl_t;

  function automatic int unsigned excess(input int unsigned ew);
    return (32'd1 << (ew - 1)) - 32'd1;
  endfunction

endpackage

// File: rtl/fpm_delay.sv
module fpm_delay #(
  parameter int unsigned W = 8,
  parameter int unsigned N = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  if (N == 0) begin : g_wire
    assign q_o = d_i;
  end else begin : g_regs
    logic [W-1:0] sr_q [N];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < int'(N); i++) sr_q[i] <= '0;
      end else begin
        sr_q[0] <= d_i;
        for (int i = 1; i < int'(N); i++) sr_q[i] <= sr_q[i-1];
      end
    end
    assign q_o = sr_q[N-1];
  end

endmodule

// File: rtl/fpm_pipe_mul.sv
// Generic pipelined unsigned multiply: operand regs, product reg, then balance regs.
module fpm_pipe_mul #(
  parameter int unsigned IN_W   = 24,
  parameter int unsigned KEEP_W = 25,
  parameter int unsigned LAT    = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IN_W-1:0]   a_i,
  input  logic [IN_W-1:0]   b_i,
  output logic [KEEP_W-1:0] p_o
);

  localparam int unsigned PROD_W = 2 * IN_W;
  localparam int unsigned DROP   = PROD_W - KEEP_W;
  localparam int unsigned TAIL   = (LAT > 2) ? LAT - 2 : 0;

  logic [IN_W-1:0]   a_q, b_q;
  logic [PROD_W-1:0] full;
  logic [KEEP_W-1:0] p_q;

  assign full = PROD_W'(a_q) * PROD_W'(b_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
      p_q <= '0;
    end else begin
      a_q <= a_i;
      b_q <= b_i;
      p_q <= KEEP_W'(full >> DROP);
    end
  end

  fpm_delay #(.W(KEEP_W), .N(TAIL)) i_tail (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (p_q),
    .q_o   (p_o)
  );

  initial begin
    if (LAT < 2) $error("fpm_pipe_mul: LAT must be at least 2");
  end

endmodule

// File: rtl/fpm_norm.sv
module fpm_norm #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    vld_i,
  input  logic                    sign_i,
  input  logic                    zero_i,
  input  logic [EXP_W-1:0]        exp_i,
  input  logic [FRAC_W+1:0]       prod_i,
  output logic                    vld_o,
  output logic [EXP_W+FRAC_W:0]   res_o
);

  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W;

  logic              hi;
  logic [FRAC_W-1:0] frac_n;
  logic [EXP_W-1:0]  exp_n;

  assign hi     = prod_i[FRAC_W+1];
  assign frac_n = hi ? prod_i[FRAC_W:1] : prod_i[FRAC_W-1:0];
  assign exp_n  = exp_i + EXP_W'(hi);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      res_o <= '0;
    end else begin
      vld_o <= vld_i;
      res_o <= zero_i ? '0 : {sign_i, exp_n, frac_n};
    end
  end

  AST_LEAD_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i && !zero_i |-> (prod_i[FRAC_W+1] || prod_i[FRAC_W])); // R4

  AST_ZERO_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i && zero_i |=> res_o == '0); // R6

  AST_SIGN_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i && !zero_i |=> res_o[WORD_W-1] == $past(sign_i)); // R2

endmodule

// File: rtl/fp_mul_pipe.sv
module fp_mul_pipe #(
  parameter int unsigned EXP_W   = 8,
  parameter int unsigned FRAC_W  = 23,
  parameter int unsigned MUL_LAT = 5
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [EXP_W+FRAC_W:0] a_i,
  input  logic [EXP_W+FRAC_W:0] b_i,
  output logic                  valid_o,
  output logic [EXP_W+FRAC_W:0] result_o
);

  import fpm_pkg::*;

  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W;
  localparam int unsigned MAN_W  = FRAC_W + 1;
  localparam int unsigned KEEP_W = FRAC_W + 2;
  localparam int unsigned SIDE_W = $bits(fpm_ctl_t) + EXP_W;
  localparam logic [EXP_W-1:0] BIAS = EXP_W'(excess(EXP_W));

  logic [EXP_W-1:0]  ea, eb, exp_sum, exp_d;
  logic [MAN_W-1:0]  ma, mb;
  logic [KEEP_W-1:0] prod;
  fpm_ctl_t          ctl_in, ctl_d;

  assign ea = a_i[WORD_W-2 -: EXP_W];
  assign eb = b_i[WORD_W-2 -: EXP_W];
  assign ma = {1'b1, a_i[FRAC_W-1:0]};
  assign mb = {1'b1, b_i[FRAC_W-1:0]};

  // biased sum wraps modulo 2^EXP_W by design
  assign exp_sum     = ea + eb - BIAS;
  assign ctl_in.vld  = valid_i;
  assign ctl_in.sign = a_i[WORD_W-1] ^ b_i[WORD_W-1];
  assign ctl_in.zero = (ea == '0) || (eb == '0);

  fpm_pipe_mul #(.IN_W(MAN_W), .KEEP_W(KEEP_W), .LAT(MUL_LAT)) i_mul (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .a_i   (ma),
    .b_i   (mb),
    .p_o   (prod)
  );

  fpm_delay #(.W(SIDE_W), .N(MUL_LAT)) i_side (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ctl_in, exp_sum}),
    .q_o   ({ctl_d, exp_d})
  );

  fpm_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_norm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (ctl_d.vld),
    .sign_i(ctl_d.sign),
    .zero_i(ctl_d.zero),
    .exp_i (exp_d),
    .prod_i(prod),
    .vld_o (valid_o),
    .res_o (result_o)
  );

  AST_VALID_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(valid_o)); // R7

endmodule

// File: tb/test_fp_mul_pipe.sv
module test_fp_mul_pipe;

  localparam int EW  = 8;
  localparam int FW  = 23;
  localparam int LAT = 6;
  localparam int WW  = 1 + EW + FW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [WW-1:0] a_i = '0, b_i = '0;
  logic          valid_o;
  logic [WW-1:0] result_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  int step_n  = 0;

  logic          q_v [8];
  logic [WW-1:0] q_r [8];
  string         q_t [8];

  always #2 clk_i = ~clk_i;

  fp_mul_pipe #(.EXP_W(EW), .FRAC_W(FW), .MUL_LAT(5)) i_fp_mul_pipe (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .a_i(a_i), .b_i(b_i), .valid_o(valid_o), .result_o(result_o)
  );

  function automatic logic [WW-1:0] ref_mul(input logic [WW-1:0] a, input logic [WW-1:0] b);
    logic [47:0] p;
    logic [EW-1:0] ea, eb, e;
    logic [FW-1:0] f;
    ea = a[WW-2 -: EW];
    eb = b[WW-2 -: EW];
    if (ea == 0 || eb == 0) return '0;
    p = 48'({1'b1, a[FW-1:0]}) * 48'({1'b1, b[FW-1:0]});
    f = p[47] ? p[46:24] : p[45:23];
    e = EW'(int'(ea) + int'(eb) - 127 + int'(p[47]));
    return {a[WW-1] ^ b[WW-1], e, f};
  endfunction

  function automatic string classify(input logic [WW-1:0] a, input logic [WW-1:0] b);
    logic [47:0] p;
    int s;
    if (a[WW-2 -: EW] == 0 || b[WW-2 -: EW] == 0) return "R6";
    p = 48'({1'b1, a[FW-1:0]}) * 48'({1'b1, b[FW-1:0]});
    s = int'(a[WW-2 -: EW]) + int'(b[WW-2 -: EW]) - 127 + int'(p[47]);
    if (s < 0 || s > 255) return "R9";
    if (p[47]) return "R4";
    return "R3";
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [WW-1:0] a, input logic [WW-1:0] b, input string tag);
    int rd, wr;
    @(negedge clk_i);
    rd = (step_n + 2) % 8;
    wr = step_n % 8;
    if (q_v[rd]) begin
      chk(valid_o === 1'b1, "R7", WW'(valid_o), WW'(1));
      chk(result_o === q_r[rd], q_t[rd], result_o, q_r[rd]);
    end else begin
      chk(valid_o === 1'b0, "R7", WW'(valid_o), '0);
    end
    q_v[wr] = v;
    q_r[wr] = ref_mul(a, b);
    q_t[wr] = tag;
    valid_i = v;
    a_i = a;
    b_i = b;
    step_n++;
  endtask

  function automatic logic [WW-1:0] rnd_op();
    logic [EW-1:0] e;
    e = EW'($urandom);
    if ($urandom_range(0, 9) == 0) e = '0;
    return {1'($urandom), e, FW'($urandom)};
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [WW-1:0] a, b;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 8; i++) begin
      q_v[i] = 1'b0; q_r[i] = '0; q_t[i] = "R8";
    end
    repeat (3) @(negedge clk_i);
    // R8: outputs idle during reset
    chk(valid_o === 1'b0 && result_o === '0, "R8", result_o, '0);
    rst_ni = 1'b1;
    // R8: stays idle until first result, checked through R7 slots
    for (int i = 0; i < LAT; i++) step(1'b0, '0, '0, "R8");
    // R1: 1.0 * 1.0 = 1.0 in sign|exp|frac layout
    step(1'b1, 32'h3F80_0000, 32'h3F80_0000, "R1");
    // R4: 1.5 * 1.5 = 2.25
    step(1'b1, 32'h3FC0_0000, 32'h3FC0_0000, "R4");
    // R2: -2 * 3 = -6
    step(1'b1, 32'hC000_0000, 32'h4040_0000, "R2");
    step(1'b1, 32'hC000_0000, 32'hC040_0000, "R2");
    // R5: max fraction squared truncates
    step(1'b1, 32'h3FFF_FFFF, 32'h3FFF_FFFF, "R5");
    step(1'b1, 32'h3F80_0001, 32'h3FFF_FFFF, "R5");
    // R6: zero exponent on either side
    step(1'b1, 32'h8000_1234, 32'h4040_0000, "R6");
    step(1'b1, 32'h4040_0000, 32'h007F_FFFF, "R6");
    // R9: overflow and underflow wrap
    step(1'b1, 32'h7F00_0000, 32'h7F00_0000, "R9");
    step(1'b1, 32'h0080_0000, 32'h0080_0000, "R9");
    step(1'b1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R9");
    // R3: below-two product, bubble then back-to-back
    step(1'b0, 32'h3F80_0000, 32'h3F80_0000, "R3");
    step(1'b1, 32'h3F90_0000, 32'h4000_0000, "R3");
    for (int i = 0; i < 3000; i++) begin
      a = rnd_op();
      b = rnd_op();
      step(($urandom_range(0, 3) != 0), a, b, classify(a, b));
    end
    for (int i = 0; i < 8; i++) step(1'b0, '0, '0, "R7");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule